// File: doc/BRIEF.md
# Buffer Occupancy Rate Detector

This block serves as the phase detector of an adaptive clock recovery loop. In such a loop the write side of a receive buffer arrives in bursts, while the read side runs continuously. The block does not compare two clock phases. It keeps a running occupancy value instead: each write strobe adds one and each read strobe removes one. It then sets that value against two programmable thresholds, one placed near the empty end of the buffer and one near the full end.

The result of that comparison has three outcomes:

- When occupancy sits inside the window, the frequency is held.
- When occupancy drops below the low threshold, a slow-down request is raised.
- When occupancy climbs above the high threshold, a speed-up request is raised.

Both requests are registered. A later frequency-control stage (a counter, charge pump or filter) consumes them. The occupancy counter never wraps: it stops at empty and at full, and it reports each blocked step with a one-cycle flag.

Top module: `rate_det`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied, `level` is 0 and `rate_up`, `rate_dn`, `overflow` and `underflow` are all 0.
- R2: A write strobe alone raises `level` by one, and a read strobe alone lowers it by one. The new value appears after the next rising clock edge.
- R3: A write and a read strobe in the same cycle leave `level` unchanged and raise no flag, including when the buffer is empty or full.
- R4: A lone write strobe while `level` equals DEPTH leaves `level` at DEPTH and pulses `overflow` for exactly one cycle. `level` never exceeds DEPTH.
- R5: A lone read strobe while `level` is 0 leaves `level` at 0 and pulses `underflow` for exactly one cycle.
- R6: When `lo_thr <= level <= hi_thr` (the bounds are inclusive), both `rate_up` and `rate_dn` are 0 one cycle later.
- R7: When `level < lo_thr` and `lo_thr <= hi_thr`, `rate_dn` is 1 and `rate_up` is 0 one cycle later.
- R8: When `level > hi_thr` and `lo_thr <= hi_thr`, `rate_up` is 1 and `rate_dn` is 0 one cycle later.
- R9: `rate_up` and `rate_dn` are never 1 together. When the thresholds are inverted (`lo_thr > hi_thr`), both are 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One word written into the buffer this cycle |
| rd_stb | input | 1 | One word read from the buffer this cycle |
| lo_thr | input | LW | Low threshold, near the empty end |
| hi_thr | input | LW | High threshold, near the full end |
| rate_up | output | 1 | Request to speed up the read clock |
| rate_dn | output | 1 | Request to slow down the read clock |
| level | output | LW | Current occupancy, from 0 to DEPTH |
| overflow | output | 1 | One-cycle pulse: a write was blocked at full |
| underflow | output | 1 | One-cycle pulse: a read was blocked at empty |

## Verification
The bound checker watches several properties on every cycle:

- the two rate requests never overlap;
- the occupancy moves by at most one per cycle and never passes DEPTH;
- a simultaneous strobe pair leaves the occupancy still;
- each saturation flag appears only with the occupancy pinned at its limit;
- each rate request follows, one cycle later, the window decision for the previous level and thresholds.

The directed scenarios supply what the checker cannot show on its own:

- the exact occupancy values along fill and drain sequences;
- the inclusive window edges at both thresholds;
- the single-cycle width of the saturation pulses;
- the behaviour when the thresholds are programmed inverted.

// File: rtl/rate_det_pkg.sv
package rate_det_pkg;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_INC,
        STEP_DEC
    } step_e;

    typedef enum logic [1:0] {
        RATE_HOLD,
        RATE_FASTER,
        RATE_SLOWER
    } rate_e;

    // A write and a read in the same cycle cancel out.
    function automatic step_e decode_step(input logic wr, input logic rd);
        step_e s;
        unique case ({wr, rd})
            2'b10:   s = STEP_INC;
            2'b01:   s = STEP_DEC;
            default: s = STEP_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rate_det_occ.sv
module rate_det_occ
    import rate_det_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    output logic [LW-1:0] level,
    output logic          overflow,
    output logic          underflow
);

    localparam logic [LW-1:0] FULL  = LW'(DEPTH);
    localparam logic [LW-1:0] EMPTY = '0;

    typedef struct packed {
        logic [LW-1:0] level;
        logic          ovf;
        logic          unf;
    } occ_t;

    occ_t  occ_d, occ_q;
    step_e step;

    always_comb begin
        step      = decode_step(wr_stb, rd_stb);
        occ_d     = occ_q;
        occ_d.ovf = 1'b0;
        occ_d.unf = 1'b0;
        unique case (step)
            STEP_INC: begin
                if (occ_q.level == FULL) occ_d.ovf = 1'b1;
                else                     occ_d.level = occ_q.level + 1'b1;
            end
            STEP_DEC: begin
                if (occ_q.level == EMPTY) occ_d.unf = 1'b1;
                else                      occ_d.level = occ_q.level - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign level     = occ_q.level;
    assign overflow  = occ_q.ovf;
    assign underflow = occ_q.unf;

endmodule

// File: rtl/rate_det_cmp.sv
module rate_det_cmp
    import rate_det_pkg::*;
#(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] lo_thr,
    input  logic [LW-1:0] hi_thr,
    output logic          rate_up,
    output logic          rate_dn
);

    typedef struct packed {
        logic up;
        logic dn;
    } req_t;

    req_t  req_d, req_q;
    rate_e decision;

    always_comb begin
        decision = RATE_HOLD;
        // An inverted window gives no valid decision, so the loop holds.
        if (lo_thr <= hi_thr) begin
            if (level > hi_thr)      decision = RATE_FASTER;
            else if (level < lo_thr) decision = RATE_SLOWER;
        end
        req_d.up = (decision == RATE_FASTER);
        req_d.dn = (decision == RATE_SLOWER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign rate_up = req_q.up;
    assign rate_dn = req_q.dn;

endmodule

// File: rtl/rate_det.sv
module rate_det
    import rate_det_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [LW-1:0] lo_thr,
    input  logic [LW-1:0] hi_thr,
    output logic          rate_up,
    output logic          rate_dn,
    output logic [LW-1:0] level,
    output logic          overflow,
    output logic          underflow
);

    logic [LW-1:0] occ_level;

    rate_det_occ #(.DEPTH(DEPTH), .LW(LW)) occ_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .level     (occ_level),
        .overflow  (overflow),
        .underflow (underflow)
    );

    rate_det_cmp #(.LW(LW)) cmp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (occ_level),
        .lo_thr  (lo_thr),
        .hi_thr  (hi_thr),
        .rate_up (rate_up),
        .rate_dn (rate_dn)
    );

    assign level = occ_level;

endmodule

// File: rtl/rate_det_chk.sv
module rate_det_chk #(
    parameter int DEPTH = 1024,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_stb,
    input logic          rd_stb,
    input logic [LW-1:0] lo_thr,
    input logic [LW-1:0] hi_thr,
    input logic          rate_up,
    input logic          rate_dn,
    input logic [LW-1:0] level,
    input logic          overflow,
    input logic          underflow
);

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    p_mutex_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rate_up && rate_dn));

    p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (level == $past(level) || level == $past(level) + 1'b1
                       || level == $past(level) - 1'b1));

    p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(wr_stb && rd_stb)) |-> ($stable(level) && !overflow && !underflow));

    p_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && overflow) |-> (level == LW'(DEPTH) && $stable(level)));

    p_unf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && underflow) |-> (level == '0 && $stable(level)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(level >= lo_thr && level <= hi_thr)) |-> (!rate_up && !rate_dn));

    p_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(lo_thr <= hi_thr && level < lo_thr)) |-> rate_dn);

    p_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(lo_thr <= hi_thr && level > hi_thr)) |-> rate_up);

    p_inverted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(lo_thr > hi_thr)) |-> (!rate_up && !rate_dn));

endmodule

bind rate_det rate_det_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .lo_thr    (lo_thr),
    .hi_thr    (hi_thr),
    .rate_up   (rate_up),
    .rate_dn   (rate_dn),
    .level     (level),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/rate_det_tb_top.sv
`timescale 1ns/1ps
module rate_det_tb_top;

    localparam int DEPTH = 16;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [LW-1:0] lo_thr = LW'(4);
    logic [LW-1:0] hi_thr = LW'(12);
    logic          rate_up, rate_dn, overflow, underflow;
    logic [LW-1:0] level;

    int checks = 0;
    int errors = 0;
    int exp_lvl = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rate_det #(.DEPTH(DEPTH), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .lo_thr(lo_thr), .hi_thr(hi_thr), .rate_up(rate_up), .rate_dn(rate_dn),
        .level(level), .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply strobes for one cycle, driven and sampled at the falling edge.
    task automatic cyc(input logic w, input logic r);
        wr_stb = w;
        rd_stb = r;
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic check_rate(input string req, input int up, input int dn);
        check(req, "rate_up", int'(rate_up), up);
        check(req, "rate_dn", int'(rate_dn), dn);
    endtask

    task automatic t_reset();
        check("R1", "level", int'(level), 0);
        check_rate("R1", 0, 0);
        check("R1", "overflow", int'(overflow), 0);
        check("R1", "underflow", int'(underflow), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_lvl = 0;
        check_rate("R7", 0, 1);
    endtask

    task automatic t_fill_window();
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b0);
            exp_lvl++;
            check("R2", "level up", int'(level), exp_lvl);
        end
        check_rate("R7", 0, 1);
        cyc(1'b0, 1'b0);
        check_rate("R6", 0, 0);
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 1'b0);
            exp_lvl++;
        end
        check("R2", "level", int'(level), 12);
        cyc(1'b0, 1'b0);
        check_rate("R6", 0, 0);
        cyc(1'b1, 1'b0);
        exp_lvl++;
        cyc(1'b0, 1'b0);
        check_rate("R8", 1, 0);
    endtask

    task automatic t_pair();
        cyc(1'b1, 1'b1);
        check("R3", "level", int'(level), exp_lvl);
        check("R3", "overflow", int'(overflow), 0);
        check("R3", "underflow", int'(underflow), 0);
    endtask

    task automatic t_overflow();
        while (exp_lvl < DEPTH) begin
            cyc(1'b1, 1'b0);
            exp_lvl++;
        end
        check("R4", "level full", int'(level), DEPTH);
        check("R4", "no early overflow", int'(overflow), 0);
        cyc(1'b1, 1'b1);
        check("R3", "level at full", int'(level), DEPTH);
        check("R3", "overflow on pair", int'(overflow), 0);
        cyc(1'b1, 1'b0);
        check("R4", "level held", int'(level), DEPTH);
        check("R4", "overflow", int'(overflow), 1);
        cyc(1'b0, 1'b0);
        check("R4", "overflow width", int'(overflow), 0);
        check_rate("R8", 1, 0);
    endtask

    task automatic t_underflow();
        while (exp_lvl > 0) begin
            cyc(1'b0, 1'b1);
            exp_lvl--;
        end
        check("R2", "level drained", int'(level), 0);
        cyc(1'b1, 1'b1);
        check("R3", "level at empty", int'(level), 0);
        check("R3", "underflow on pair", int'(underflow), 0);
        cyc(1'b0, 1'b1);
        check("R5", "level held", int'(level), 0);
        check("R5", "underflow", int'(underflow), 1);
        cyc(1'b0, 1'b0);
        check("R5", "underflow width", int'(underflow), 0);
        check_rate("R7", 0, 1);
    endtask

    task automatic t_inverted();
        lo_thr = LW'(10);
        hi_thr = LW'(3);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        check_rate("R9", 0, 0);
        for (int i = 0; i < 14; i++) cyc(1'b1, 1'b0);
        exp_lvl = 14;
        cyc(1'b0, 1'b0);
        check("R2", "level", int'(level), 14);
        check_rate("R9", 0, 0);
        lo_thr = LW'(14);
        hi_thr = LW'(14);
        cyc(1'b0, 1'b0);
        check_rate("R6", 0, 0);
        hi_thr = LW'(13);
        lo_thr = LW'(13);
        cyc(1'b0, 1'b0);
        check_rate("R8", 1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #5;
        t_reset();
        t_fill_window();
        t_pair();
        t_overflow();
        t_underflow();
        t_inverted();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule